// File: doc/BRIEF.md
# I2C Quad Wiper Register Bank

This block is the digital control side of a four-channel variable resistor. It is an I2C slave that holds four independent 8-bit tap codes, one per resistor channel, and presents them in parallel to the analog section. A host addresses the slave, sends a pointer byte that picks one of the four channels, and then either writes a new tap code or reads the current one back. No other register set exists. The pointer persists between transfers, so a read that has no pointer phase returns the channel named last.

The bus lines are oversampled on the system clock through two-flop synchronizers. Edge detection on the synchronized lines gives SCL rising and falling events, START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). The slave never drives SCL. It pulls SDA low through an open-drain output enable, `sda_oe`, where 1 means the pad is driven low. A power-up window of `PWRUP_CYCLES` clocks after reset release ignores any START, so a bus that is still settling cannot open a transfer.

The control state machine has these states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK acknowledges a matching address. ST_PTR shifts in the pointer byte. ST_PTR_ACK acknowledges a valid pointer. ST_WDATA shifts in the data byte. ST_WDATA_ACK acknowledges the data byte and commits it. ST_RDATA shifts a tap code out. ST_RDATA_ACK listens for the host's acknowledge. ST_IGNORE stays off the bus. The transitions are as follows. A START accepted after the power-up window moves any state to ST_ADDR. A STOP moves any state to ST_IDLE. The end of the eighth bit moves ST_ADDR to ST_ADDR_ACK if the address matches and to ST_IGNORE if it does not. The end of the eighth bit moves ST_PTR to ST_PTR_ACK if the pointer is valid and to ST_IGNORE if it is not. The end of the eighth bit moves ST_WDATA to ST_WDATA_ACK. On the falling edge of the acknowledge clock, ST_ADDR_ACK moves to ST_RDATA for a read or to ST_PTR for a write. On the same edge, ST_PTR_ACK moves to ST_WDATA and ST_WDATA_ACK moves to ST_IGNORE. The eighth falling SCL edge moves ST_RDATA to ST_RDATA_ACK. In ST_RDATA_ACK, a host acknowledge moves the block back to ST_RDATA and a host not-acknowledge moves it to ST_IGNORE.

Top module: `i2c_wiper_bank`

## Requirements
- R1: While reset is asserted, and right after it is released, all four wiper codes equal 80h and `sda_oe` is 0.
- R2: A transfer begins only on a START, which is an SDA fall while SCL is high. Bytes clocked in before any START get no acknowledge.
- R3: A START that occurs within the first `PWRUP_CYCLES` clocks after reset release is ignored. The bytes that follow it get no acknowledge and change no wiper.
- R4: The first byte after a START is taken MSB first. Bits 7:1 are the device address and bit 0 is 1 for a read. A byte whose bits 7:1 equal `DEV_ADDR` is acknowledged by driving `sda_oe` high during the ninth clock. On a mismatch the block does not acknowledge that byte or any later byte until the next START or STOP.
- R5: In a write, the byte after the address is a pointer. The values 00h, 01h, 02h and 03h select wiper 0, 1, 2 and 3 and are acknowledged. A value above 03h is not acknowledged, changes no wiper, and leaves the stored pointer as it was.
- R6: After a valid pointer, one data byte is taken MSB first and acknowledged, and it is written to the selected wiper on the SCL rise of its acknowledge clock. Any further byte in the same transfer gets no acknowledge and writes nothing.
- R7: In a read, the wiper named by the stored pointer is shifted out MSB first. The first bit appears right after the address acknowledge. A host acknowledge makes the same code repeat, and a host not-acknowledge releases the bus.
- R8: A STOP, which is an SDA rise while SCL is high, returns the block to idle from any state. Bytes clocked after it without a new START get no acknowledge.
- R9: A repeated START in any state aborts the transfer in progress, writes nothing, and restarts address reception.
- R10: `wiper_o[8*i+7:8*i]` carries wiper i. The wiper codes change only through an acknowledged data byte.
- R11: `sda_oe` is 1 only during an acknowledge clock of a byte the slave received, or while a 0 bit of read data is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | NUM_WIPERS*WIPER_W | Packed tap codes, wiper i in slice i |

## Verification
On every cycle, the assertions check four things: the wiper codes hold still unless a write commit is under way, a STOP always lands in idle, an accepted START always lands in address reception, and the state machine stays idle for the whole power-up window. They also check that the slave never pulls SDA while it is idle or ignoring the bus, and that the reset value is present on the first cycle out of reset. The bench's scenarios cover the parts that depend on a whole sequence. These include MSB-first ordering of real codes, acknowledge or no acknowledge per byte, a pointer that survives a rejected pointer byte, a repeated read that returns the same code, and an abort by a repeated START before any data byte.

// File: rtl/i2c_wb_pkg.sv
package i2c_wb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-flop synchronizer for one bus line plus a one-cycle delayed copy
// used for edge detection.
module i2c_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic sync_o,
    output logic prev_o
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= {STAGES{IDLE_LV}};
            prev_o <= IDLE_LV;
        end else begin
            chain  <= {chain[STAGES-2:0], line_i};
            prev_o <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
// Decodes clock edges and START/STOP from synchronized line pairs.
module i2c_bus_events (
    input  logic scl_now,
    input  logic scl_old,
    input  logic sda_now,
    input  logic sda_old,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_now & scl_old;
        scl_rise      = scl_now & ~scl_old;
        scl_fall      = ~scl_now & scl_old;
        start_det     = scl_held_high & sda_old & ~sda_now;
        stop_det      = scl_held_high & ~sda_old & sda_now;
    end

endmodule

// File: rtl/wb_pwrup_guard.sv
// Counts a fixed window after reset release; START is refused until done.
module wb_pwrup_guard #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);

    localparam int CNT_W = (CYCLES > 0) ? $clog2(CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    assign done_o = (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!done_o) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wiper_regfile.sv
// Bank of volatile tap-code registers with one write port and one read port.
module wiper_regfile #(
    parameter int NUM   = 4,
    parameter int W     = 8,
    parameter int INIT  = 128,
    parameter int IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [W-1:0]       wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [W-1:0]       rd_data,
    output logic [NUM*W-1:0]   codes_o
);

    localparam logic [W-1:0] INIT_CODE = W'(INIT);

    logic [W-1:0] regs [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_wiper
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= INIT_CODE;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs[i] <= wr_data;
            end
        end
        assign codes_o[i*W +: W] = regs[i];
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/i2c_wiper_bank.sv
// I2C slave holding four tap-code registers selected by a pointer byte.
module i2c_wiper_bank
    import i2c_wb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h28,
    parameter int         NUM_WIPERS   = 4,
    parameter int         WIPER_W      = 8,
    parameter int         RESET_CODE   = 128,
    parameter int         SYNC_STAGES  = 2,
    parameter int         PWRUP_CYCLES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe,
    output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o
);

    localparam int IDX_W = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
    localparam logic [BYTE_W-1:0] PTR_LIMIT = BYTE_W'(NUM_WIPERS);
    localparam logic [3:0] LAST_BIT  = 4'd7;
    localparam logic [3:0] FULL_BYTE = 4'd8;

    // synchronized lines and bus events
    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic pwr_done, start_ok;

    // control and datapath state
    bus_state_t        state, nstate;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [3:0]        bit_cnt;
    logic              rd_mode;
    logic [IDX_W-1:0]  ptr;

    // decoded conditions
    logic              byte_done, addr_match, ptr_ok, tx_load;
    logic              wr_en;
    logic [WIPER_W-1:0] rd_data;
    logic [BYTE_W-1:0] rd_byte;
    logic              tx_msb_next;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .sync_o(scl_s), .prev_o(scl_p)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .sync_o(sda_s), .prev_o(sda_p)
    );

    i2c_bus_events u_events (
        .scl_now(scl_s), .scl_old(scl_p), .sda_now(sda_s), .sda_old(sda_p),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    wb_pwrup_guard #(.CYCLES(PWRUP_CYCLES)) u_guard (
        .clk(clk), .rst_n(rst_n), .done_o(pwr_done)
    );

    wiper_regfile #(
        .NUM(NUM_WIPERS), .W(WIPER_W), .INIT(RESET_CODE), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx_sh[WIPER_W-1:0]),
        .rd_idx(ptr), .rd_data(rd_data), .codes_o(wiper_o)
    );

    always_comb begin
        start_ok   = start_det & pwr_done;
        byte_done  = scl_fall && (bit_cnt == FULL_BYTE);
        addr_match = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
        ptr_ok     = (rx_sh < PTR_LIMIT);
        rd_byte    = BYTE_W'(rd_data);
        wr_en      = (state == ST_WDATA_ACK) && scl_rise;
    end

    // next-state decision
    always_comb begin
        nstate = state;
        if (stop_det) begin
            nstate = ST_IDLE;
        end else if (start_ok) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_ADDR:      if (byte_done) nstate = addr_match ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  nstate = rd_mode ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nstate = ptr_ok ? ST_PTR_ACK : ST_IGNORE;
                ST_PTR_ACK:   if (scl_fall)  nstate = ST_WDATA;
                ST_WDATA:     if (byte_done) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nstate = ST_IGNORE;
                ST_RDATA:     if (scl_fall && (bit_cnt == LAST_BIT)) nstate = ST_RDATA_ACK;
                ST_RDATA_ACK: begin
                    if (scl_rise && sda_s) nstate = ST_IGNORE;
                    else if (scl_fall)     nstate = ST_RDATA;
                end
                ST_IGNORE:    nstate = ST_IGNORE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    assign tx_load = (nstate == ST_RDATA) && (state != ST_RDATA);

    // shift registers, bit counter, direction and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            ptr     <= '0;
        end else if (start_ok || stop_det) begin
            bit_cnt <= '0;
        end else if (tx_load) begin
            tx_sh   <= rd_byte;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if ((state == ST_ADDR) && byte_done) begin
                        rd_mode <= rx_sh[0];
                    end
                    if ((state == ST_PTR) && byte_done && ptr_ok) begin
                        ptr <= rx_sh[IDX_W-1:0];
                    end
                end
                ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK, ST_RDATA_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // bit that will sit on SDA once the next state is in place
    always_comb begin
        if (tx_load)                           tx_msb_next = rd_byte[BYTE_W-1];
        else if (state == ST_RDATA && scl_fall) tx_msb_next = tx_sh[BYTE_W-2];
        else                                   tx_msb_next = tx_sh[BYTE_W-1];
    end

    // registered open-drain output, decided from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else begin
            unique case (nstate)
                ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe <= 1'b1;
                ST_RDATA:                              sda_oe <= ~tx_msb_next;
                default:                               sda_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/wb_chk.sv
module wb_chk
    import i2c_wb_pkg::*;
#(
    parameter int NUM_WIPERS = 4,
    parameter int WIPER_W    = 8,
    parameter int RESET_CODE = 128
) (
    input logic                          clk,
    input logic                          rst_n,
    input bus_state_t                    state,
    input logic                          start_det,
    input logic                          stop_det,
    input logic                          pwr_done,
    input logic                          wr_en,
    input logic                          sda_oe,
    input logic [NUM_WIPERS*WIPER_W-1:0] wiper_o
);

    localparam logic [NUM_WIPERS*WIPER_W-1:0] ALL_RESET = {NUM_WIPERS{WIPER_W'(RESET_CODE)}};

    // R1
    reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wiper_o == ALL_RESET));

    // R10
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wiper_o));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R9
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && pwr_done) |=> (state == ST_ADDR));

    // R3
    pwrup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |=> (state == ST_IDLE));

    // R11
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> ((state != ST_IDLE) && (state != ST_IGNORE)));

endmodule

bind i2c_wiper_bank wb_chk #(
    .NUM_WIPERS(NUM_WIPERS), .WIPER_W(WIPER_W), .RESET_CODE(RESET_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .start_det(start_det),
    .stop_det(stop_det), .pwr_done(pwr_done), .wr_en(wr_en),
    .sda_oe(sda_oe), .wiper_o(wiper_o)
);

// File: tb/sim_i2c_wiper_bank.sv
module sim_i2c_wiper_bank;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] ADDR = 7'h28;
    localparam int NVEC = 8;
    // {pointer byte, data byte}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h003C, 16'h01FF, 16'h0200, 16'h03A5,
        16'h0511, 16'h015A, 16'h0477, 16'h0301
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [31:0] wiper_o;
    logic [7:0] model [4];
    int checks = 0;
    int errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    i2c_wiper_bank u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wiper_o(wiper_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q/2);
        ack = ~sda_line;
        wait_clk(Q/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q);
            scl_m = 1'b1; wait_clk(Q/2);
            b[i] = sda_line;
            wait_clk(Q/2);
            scl_m = 1'b0;
        end
        sda_m = ~host_ack; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        scl_m = 1'b0;
    endtask

    task automatic check_codes(input string req);
        for (int i = 0; i < 4; i++) begin
            check(wiper_o[i*8 +: 8] == model[i], req, int'(wiper_o[i*8 +: 8]), int'(model[i]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] rb, rb2;
        for (int i = 0; i < 4; i++) model[i] = 8'h80;

        // R1: reset state
        wait_clk(5);
        check_codes("R1 codes in reset");
        check(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;

        // R3: START inside power-up window is refused
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        check(a0 == 1'b0, "R3 addr after early start", int'(a0), 0);
        send_byte(8'h00, a1);
        send_byte(8'h11, a2);
        check(a1 == 1'b0 && a2 == 1'b0, "R3 bytes after early start", int'({a1, a2}), 0);
        bus_stop();
        check_codes("R3 codes untouched");

        // R2: bytes with no START are ignored
        send_byte({ADDR, 1'b0}, a0);
        check(a0 == 1'b0, "R2 addr without start", int'(a0), 0);
        wait_clk(Q);

        // Vector table: write, then read back through a repeated START
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] p, d;
            logic valid;
            p = VEC[v][15:8];
            d = VEC[v][7:0];
            valid = (p < 8'h04);
            bus_start();
            send_byte({ADDR, 1'b0}, a0);
            check(a0 == 1'b1, "R4 address ack", int'(a0), 1);
            send_byte(p, a1);
            check(a1 == valid, "R5 pointer ack", int'(a1), int'(valid));
            if (a1) begin
                send_byte(d, a2);
                check(a2 == 1'b1, "R6 data ack", int'(a2), 1);
            end
            bus_stop();
            if (valid) model[p[1:0]] = d;
            check_codes("R10 codes after write");
            if (valid) begin
                bus_start();
                send_byte({ADDR, 1'b0}, a0);
                send_byte(p, a1);
                bus_start();
                send_byte({ADDR, 1'b1}, a2);
                recv_byte(1'b0, rb);
                bus_stop();
                check(rb == d, "R7 read back", int'(rb), int'(d));
            end
        end

        // R4: wrong address gets no ack and stays off the bus
        bus_start();
        send_byte({ADDR ^ 7'h01, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h00, a2);
        bus_stop();
        check(a0 == 1'b0 && a1 == 1'b0 && a2 == 1'b0, "R4 mismatch silent", int'({a0, a1, a2}), 0);
        check_codes("R4 codes after mismatch");

        // R6: second data byte in one transfer refused
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h02, a1);
        send_byte(8'h66, a2);
        send_byte(8'h99, a3);
        bus_stop();
        model[2] = 8'h66;
        check(a3 == 1'b0, "R6 extra byte nack", int'(a3), 0);
        check_codes("R6 one byte written");

        // R7: direct read with host ack repeats the same code
        bus_start();
        send_byte({ADDR, 1'b1}, a0);
        recv_byte(1'b1, rb);
        recv_byte(1'b0, rb2);
        bus_stop();
        check(rb == 8'h66, "R7 first byte", int'(rb), 'h66);
        check(rb2 == 8'h66, "R7 repeated byte", int'(rb2), 'h66);

        // R5: rejected pointer keeps the stored pointer
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h01, a1);
        bus_stop();
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h07, a1);
        bus_stop();
        bus_start();
        send_byte({ADDR, 1'b1}, a0);
        recv_byte(1'b0, rb);
        bus_stop();
        check(rb == model[1], "R5 pointer kept", int'(rb), int'(model[1]));

        // R9: repeated START aborts a write before data
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(8'h03, a1);
        bus_start();
        send_byte({ADDR, 1'b0}, a2);
        check(a2 == 1'b1, "R9 restart address ack", int'(a2), 1);
        send_byte(8'h00, a3);
        send_byte(8'h42, a1);
        bus_stop();
        model[0] = 8'h42;
        check_codes("R9 abort then rewrite");

        // R8: STOP mid-transfer returns to idle
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        bus_stop();
        send_byte(8'h00, a1);
        check(a1 == 1'b0, "R8 byte after stop", int'(a1), 0);
        bus_stop();

        // R11: bus released while idle
        wait_clk(4);
        check(sda_oe == 1'b0, "R11 released in idle", int'(sda_oe), 0);
        check_codes("R10 final codes");

        finish_run();
    end

endmodule